// File: doc/BRIEF.md
# Watchdog Supervisor With Violation Counter

This block supervises a host processor. The host must pulse a trigger input according to one of two service rules. In timeout mode, a trigger must arrive before a fixed number of cycles has elapsed. In window mode, the period starts with a closed stretch, in which a trigger is illegal, followed by an open stretch, in which a trigger is required. An external strobe lets a separate challenge-response checker report its own failures as violations.

A single violation does not reset the host. Each violation increments a counter. When a violation would take the count past a programmed limit, the block does three things: it drives an active-low host reset for a fixed number of cycles, it sets a sticky interrupt flag, and it pulls an active-low interrupt line. The counter returns to zero at that point. The host clears the flag with a write-one strobe. The period lengths, the mode and the limit come from ports. The period settings are captured only when a new service period begins.

Top module: `wdt_err_supervisor`

## Requirements
- R1: While rst_ni is low, and after it is released, rst_no and int_no are high and wd_flag_o is low until a fire event occurs.
- R2: In the first cycle after reset release, or after a reset pulse ends, the block loads its settings, and a trigger in that cycle has no effect. A service period then starts, and a trigger in any cycle of a timeout-mode period restarts it. If no trigger arrives within win_open_i cycles (mode_i = 0; a value of 0 is treated as 1), the last cycle of the period is a violation and a new period starts.
- R3: In window mode (mode_i = 1), a trigger during the first win_closed_i cycles of a period is a violation and restarts the period.
- R4: In window mode, a trigger during the next win_open_i cycles restarts the period without a violation. If no trigger arrives by the end of those cycles, the last cycle is a violation and the period restarts.
- R5: Each violation increments an error count. The violation that arrives when the count already equals or exceeds err_limit_i is a fire event, so with a limit of N, the (N+1)-th violation fires.
- R6: A fire event drives rst_no low starting at the next clock edge, for exactly WARM_CYC cycles.
- R7: A fire event sets wd_flag_o and pulls int_no low at the same edge as rst_no falls. Both stay that way after rst_no rises, until the flag is cleared.
- R8: flag_clr_i high clears the flag at the next edge, and int_no rises with it. A fire event in the same cycle wins over the clear.
- R9: A fire event resets the error count to zero, so the next fire needs err_limit_i+1 fresh violations.
- R10: ext_err_i high in a cycle counts as one violation in that cycle, whatever the timer state.
- R11: mode_i, win_closed_i and win_open_i are sampled only when a period starts. Changes in the middle of a period do not affect that period.
- R12: While rst_no is low, the timer is held, and both triggers and ext_err_i are ignored. The timer reloads its settings in the cycle after rst_no rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 timeout mode, 1 window mode |
| win_closed_i | input | LEN_W | Closed-window length in cycles (window mode) |
| win_open_i | input | LEN_W | Open-window length, or timeout length in timeout mode |
| err_limit_i | input | ERR_W | Violations tolerated before a fire event |
| trig_i | input | 1 | Service trigger from the host |
| ext_err_i | input | 1 | External violation strobe |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| wd_flag_o | output | 1 | Sticky watchdog interrupt flag |
| rst_no | output | 1 | Active-low host reset pulse |
| int_no | output | 1 | Active-low interrupt, low while the flag is set |

## Verification
The bench builds the block with LEN_W=6, ERR_W=3 and WARM_CYC=5. These short periods and this small limit range let it sweep every timeout length from 2 to 5 against every limit from 0 to 3, and every trigger offset across several closed/open window splits. Each fall and rise of rst_no is then compared, cycle for cycle, with an arithmetic prediction. The five-cycle pulse leaves room to inject strobes while reset is held, and to follow the reload and the back-to-back fire that proves the counter restarts from zero.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;
  typedef enum logic {
    WD_MODE_TIMEOUT = 1'b0,
    WD_MODE_WINDOW  = 1'b1
  } wd_mode_e;
endpackage

// File: rtl/wdt_sup_timer.sv
module wdt_sup_timer
  import wdt_sup_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  wd_mode_e         mode_i,
  input  logic [LEN_W-1:0] closed_len_i,
  input  logic [LEN_W-1:0] open_len_i,
  input  logic             trig_i,
  output logic             viol_o
);
  localparam int PER_W = LEN_W + 1;

  logic             armed_q;
  wd_mode_e         mode_q;
  logic [LEN_W-1:0] closed_q;
  logic [PER_W-1:0] end_q;
  logic [PER_W-1:0] cnt_q;

  logic [LEN_W-1:0] open_eff;
  logic [PER_W-1:0] period_in;
  logic             in_closed, last_cyc, early, late, restart, load;

  always_comb begin
    open_eff  = (open_len_i == '0) ? LEN_W'(1) : open_len_i;
    period_in = PER_W'(open_eff);
    if (mode_i == WD_MODE_WINDOW) period_in = period_in + PER_W'(closed_len_i);
  end

  always_comb begin
    in_closed = armed_q && (mode_q == WD_MODE_WINDOW) && (cnt_q < PER_W'(closed_q));
    last_cyc  = armed_q && (cnt_q == end_q - PER_W'(1));
    early     = in_closed && trig_i;
    late      = last_cyc && !trig_i;
    viol_o    = !hold_i && (early || late);
    restart   = !hold_i && armed_q && (trig_i || late);
    load      = !hold_i && (!armed_q || restart);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      mode_q   <= WD_MODE_TIMEOUT;
      closed_q <= '0;
      end_q    <= PER_W'(1);
      cnt_q    <= '0;
    end else if (hold_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load) begin
      armed_q  <= 1'b1;
      mode_q   <= mode_i;
      closed_q <= closed_len_i;
      end_q    <= period_in;
      cnt_q    <= '0;
    end else if (armed_q) begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assert_restart_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !hold_i && trig_i |=> cnt_q == '0);
  assert_cnt_in_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> cnt_q < end_q);
  assert_hold_disarms_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !armed_q);
  assert_cfg_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !load && !hold_i |=> $stable(end_q) && $stable(closed_q) && $stable(mode_q));
endmodule

// File: rtl/wdt_sup_err_cnt.sv
module wdt_sup_err_cnt #(
  parameter int ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             viol_i,
  input  logic [ERR_W-1:0] limit_i,
  output logic             fire_o
);
  logic [ERR_W-1:0] err_q;

  assign fire_o = viol_i && (err_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= '0;
    else if (fire_o) err_q <= '0;
    else if (viol_i) err_q <= err_q + ERR_W'(1);
  end

  assert_err_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i && !fire_o |=> err_q == $past(err_q) + ERR_W'(1));
  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> err_q == '0);
  assert_err_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_i |=> $stable(err_q));
endmodule

// File: rtl/wdt_sup_rst_pulse.sv
module wdt_sup_rst_pulse #(
  parameter int WARM_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  output logic active_o,
  output logic flag_o
);
  localparam int PW = (WARM_CYC < 2) ? 1 : $clog2(WARM_CYC);

  logic [PW-1:0] pcnt_q;
  logic          active_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pcnt_q   <= '0;
    end else if (fire_i) begin
      active_q <= 1'b1;
      pcnt_q   <= PW'(WARM_CYC - 1);
    end else if (active_q) begin
      if (pcnt_q == '0) active_q <= 1'b0;
      else              pcnt_q   <= pcnt_q - PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (fire_i) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign active_o = active_q;
  assign flag_o   = flag_q;

  assert_fire_starts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> active_q);
  assert_pulse_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && pcnt_q != '0 |=> active_q);
  assert_fire_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> flag_q);
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);
  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !fire_i |=> !flag_q);
endmodule

// File: rtl/wdt_err_supervisor.sv
module wdt_err_supervisor
  import wdt_sup_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int ERR_W    = 4,
  parameter int WARM_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] win_closed_i,
  input  logic [LEN_W-1:0] win_open_i,
  input  logic [ERR_W-1:0] err_limit_i,
  input  logic             trig_i,
  input  logic             ext_err_i,
  input  logic             flag_clr_i,
  output logic             wd_flag_o,
  output logic             rst_no,
  output logic             int_no
);
  logic hold, tmr_viol, viol_all, fire, flag;

  wdt_sup_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (hold),
    .mode_i      (wd_mode_e'(mode_i)),
    .closed_len_i(win_closed_i),
    .open_len_i  (win_open_i),
    .trig_i      (trig_i),
    .viol_o      (tmr_viol)
  );

  // external strobes are blanked while the host is held in reset
  assign viol_all = tmr_viol || (ext_err_i && !hold);

  wdt_sup_err_cnt #(.ERR_W(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .viol_i (viol_all),
    .limit_i(err_limit_i),
    .fire_o (fire)
  );

  wdt_sup_rst_pulse #(.WARM_CYC(WARM_CYC)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .clr_i   (flag_clr_i),
    .active_o(hold),
    .flag_o  (flag)
  );

  assign wd_flag_o = flag;
  assign rst_no    = ~hold;
  assign int_no    = ~flag;

  assert_int_with_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no) |-> !int_no);
  assert_hold_no_fire_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> !fire);
endmodule

// File: tb/tb_wdt_err_supervisor.sv
module tb_wdt_err_supervisor;
  localparam int LEN_W = 6;
  localparam int ERR_W = 3;
  localparam int WARM  = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode = 1'b0;
  logic [LEN_W-1:0] closed_len = '0, open_len = 6'd4;
  logic [ERR_W-1:0] limit = '0;
  logic trig = 1'b0, ext_err = 1'b0, clr = 1'b0;
  logic flag, rst_n_o, int_n_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  wdt_err_supervisor #(.LEN_W(LEN_W), .ERR_W(ERR_W), .WARM_CYC(WARM)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .win_closed_i(closed_len),
    .win_open_i(open_len), .err_limit_i(limit), .trig_i(trig), .ext_err_i(ext_err),
    .flag_clr_i(clr), .wd_flag_o(flag), .rst_no(rst_n_o), .int_no(int_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    trig = 1'b0; ext_err = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // negedges until rst_no reads low (or rises when want_low=0)
  task automatic wait_lvl(input bit want_low, input int maxn, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((rst_n_o == 1'b0) != want_low) && n < maxn);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, w, d;
    // R1 reset state
    @(negedge clk);
    chk(rst_n_o == 1 && int_n_o == 1 && flag == 0, "R1", {29'b0, rst_n_o, int_n_o, flag}, 6);

    // timeout sweep: R2 R5 R6 R7 R9 R8
    for (int l = 2; l <= 5; l++) begin
      for (int lim = 0; lim <= 3; lim++) begin
        mode = 1'b0; open_len = LEN_W'(l); limit = ERR_W'(lim);
        do_reset();
        chk(flag == 0 && int_n_o == 1, "R1", flag, 0);
        wait_lvl(1'b1, 300, n);
        chk(n == 1 + (lim + 1) * l, "R2 R5 first fire", n, 1 + (lim + 1) * l);
        chk(int_n_o == 0 && flag == 1, "R7 int with fire", int_n_o, 0);
        wait_lvl(1'b0, 300, w);
        chk(w == WARM, "R6 pulse width", w, WARM);
        chk(int_n_o == 0, "R7 flag sticky", int_n_o, 0);
        wait_lvl(1'b1, 300, d);
        chk(d == 1 + (lim + 1) * l, "R9 counter restarts", d, 1 + (lim + 1) * l);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(int_n_o == 1 && flag == 0, "R8 clear", int_n_o, 1);
      end
    end

    // window sweep: R3 R4
    for (int c = 1; c <= 3; c++) begin
      for (int o = 1; o <= 3; o += 2) begin
        mode = 1'b1; closed_len = LEN_W'(c); open_len = LEN_W'(o); limit = '0;
        do_reset();
        wait_lvl(1'b1, 300, n);
        chk(n == 1 + c + o, "R4 no trigger", n, 1 + c + o);
        for (int k = 0; k < c + o; k++) begin
          do_reset();
          repeat (k + 1) @(negedge clk);
          trig = 1'b1;
          @(negedge clk);
          trig = 1'b0;
          if (k < c) begin
            chk(rst_n_o == 0, "R3 early trigger", rst_n_o, 0);
          end else begin
            chk(rst_n_o == 1, "R4 open trigger", rst_n_o, 1);
            wait_lvl(1'b1, 300, n);
            chk(n == c + o, "R4 restart", n, c + o);
          end
        end
      end
    end

    // R11 mid-period change ignored, picked up at next period
    mode = 1'b0; open_len = 6'd4; closed_len = '0; limit = '0;
    do_reset();
    repeat (2) @(negedge clk);
    mode = 1'b1; closed_len = 6'd30; open_len = 6'd20;
    wait_lvl(1'b1, 300, n);
    chk(n + 2 == 5, "R11 old timeout kept", n + 2, 5);
    wait_lvl(1'b0, 300, w);
    wait_lvl(1'b1, 300, d);
    chk(d == 51, "R11 new window loaded", d, 51);

    // R10 external strobes, R12 hold
    mode = 1'b0; open_len = 6'd40; closed_len = '0; limit = 3'd2;
    do_reset();
    repeat (3) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      ext_err = 1'b1;
      @(negedge clk);
      ext_err = 1'b0;
      if (p < 2) chk(rst_n_o == 1, "R10 below limit", rst_n_o, 1);
      else       chk(rst_n_o == 0, "R10 third strobe fires", rst_n_o, 0);
      if (p < 2) @(negedge clk);
    end
    limit = '0;
    ext_err = 1'b1; trig = 1'b1;
    @(negedge clk);
    ext_err = 1'b0; trig = 1'b0;
    wait_lvl(1'b0, 300, w);
    chk(w + 1 == WARM, "R12 strobe ignored in hold", w + 1, WARM);
    wait_lvl(1'b1, 300, d);
    chk(d == 41, "R12 reload after hold", d, 41);

    // R8 fire wins over clear in same cycle
    mode = 1'b0; open_len = 6'd3; limit = '0;
    clr = 1'b1;
    do_reset();
    wait_lvl(1'b1, 300, n);
    chk(n == 4 && int_n_o == 0, "R8 fire beats clear", int_n_o, 0);
    @(negedge clk);
    chk(int_n_o == 1, "R8 clear next cycle", int_n_o, 1);
    clr = 1'b0;

    // R2 regular triggers keep host alive; trigger in load cycle ignored
    do_reset();
    w = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      if (rst_n_o == 0) w++;
    end
    chk(w == 0, "R2 serviced no fire", w, 0);
    wait_lvl(1'b1, 300, n);
    chk(n == 3, "R2 timeout after last trigger", n, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule